// File: doc/BRIEF.md
# Message Interrupt Source Controller

This block keeps the state of a set of message-style interrupt sources and hands their interrupts to a per-server presentation controller. Each source has a target server, an 8-bit priority, a rejected flag and a masked-pending flag. Priority 0xFF means the source is masked. A masked source that fires is remembered, and it is delivered later when a configuration write gives it a real priority.

Sources carry global numbers that start at a fixed base (16 by default). When an unmasked source fires, the block offers its global number, priority and server on a valid/ready channel. The presentation side can refuse an interrupt it has already taken. It does this by naming the number on the reject port. A later resend request makes the block walk every source in ascending index order, one source per cycle, and offer again each rejected source that is still unmasked. A configuration port writes or reads a source's server and priority. It checks the ranges and answers one cycle later with a status word.

Top module: `msi_src_ctl`

## Requirements
- R1: A number N is valid only when NUM_BASE <= N < NUM_BASE+NUM_SRC. Its local index is N-NUM_BASE. Every offer carries the global number (local index plus NUM_BASE).
- R2: After reset, every source reads back priority 0xFF and server 0, no flag is set and no offer is valid.
- R3: When an unmasked source fires, the block offers its global number, priority and server. When several offers wait at the same time, they go out lowest index first, one per accepted transfer.
- R4: A source with priority 0xFF that fires produces no offer and sets its masked-pending flag. A later write of a priority other than 0xFF clears the flag and offers the source once, with the new priority. A write that keeps 0xFF keeps the flag and offers nothing.
- R5: A valid reject sets the rejected flag of the named source. A resend request scans the sources in ascending index order and clears each rejected flag. It offers the source again only if its priority is not 0xFF. A second resend with no new rejects offers nothing.
- R6: While an offer is valid and offer_ready_i is low, the number, priority and server of the offer stay stable and the resend scan waits. A fire that arrives during a stall or during a scan is queued per source and offered after the scan ends.
- R7: A configuration write stores the server and priority only when the number is valid, the server is below NUM_SERVERS and the priority is at most 0xFF. The status is 0 on success. Otherwise the status is 0xFFFFFFFD (-3) and nothing changes. cfg_done_o pulses in the cycle after the request.
- R8: A configuration read of a valid number returns status 0 with the stored server and priority. A read of an out-of-range number returns status 0xFFFFFFFD.
- R9: An EOI leaves the source state unchanged. In particular, a rejected source stays rejected and is still offered again by the next resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_fire_i | input | NUM_SRC | One-cycle fire pulse per source, by local index |
| offer_valid_o | output | 1 | Offer to the presentation controller is valid |
| offer_ready_i | input | 1 | Presentation controller accepts the offer |
| offer_num_o | output | 32 | Global interrupt number offered |
| offer_prio_o | output | 8 | Priority offered |
| offer_server_o | output | SRV_W | Target server of the offer |
| reject_valid_i | input | 1 | Reject strobe |
| reject_num_i | input | 32 | Global number rejected |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | 32 | Global number of the EOI |
| resend_i | input | 1 | Start a resend scan |
| scan_busy_o | output | 1 | Resend scan in progress |
| cfg_wr_i | input | 1 | Configuration write request |
| cfg_rd_i | input | 1 | Configuration read request |
| cfg_num_i | input | 32 | Global number addressed |
| cfg_server_i | input | 32 | Server to write |
| cfg_prio_i | input | 32 | Priority to write |
| cfg_done_o | output | 1 | Response valid, one cycle after a request |
| cfg_status_o | output | 32 | 0 for success, 0xFFFFFFFD for an error |
| cfg_server_o | output | 32 | Server read back |
| cfg_prio_o | output | 8 | Priority read back |

## Verification
The assertions assume that reject and EOI numbers name sources the block offered. They also assume that offer_ready_i only changes between clock edges and that a configuration write and read are never requested in the same cycle. The stimulus drives all inputs on the falling edge and never issues a write and a read together. It rejects only numbers inside the valid range and drops ready only to create stalls on purpose. The masked-pending, reject and queued-fire paths are each reached from reset through the configuration port, so no hidden state is preloaded.

// File: rtl/msi_src_pkg.sv
package msi_src_pkg;

  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_ERR  = 32'hFFFF_FFFD;
  localparam logic [7:0]  PRIO_OFF = 8'hFF;

  function automatic logic num_ok(logic [31:0] n, int unsigned base, int unsigned cnt);
    return (n >= base) && (n < base + cnt);
  endfunction

  function automatic logic is_masked(logic [7:0] p);
    return p == PRIO_OFF;
  endfunction

  function automatic logic wr_ok(logic [31:0] n, logic [31:0] srv, logic [31:0] prio,
                                 int unsigned base, int unsigned cnt, int unsigned nsrv);
    return num_ok(n, base, cnt) && (srv < nsrv) && (prio <= 32'd255);
  endfunction

endpackage

// File: rtl/msi_src_table.sv
module msi_src_table
  import msi_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              fire_i,
  input  logic [NUM_SRC-1:0]              rej_hit_i,
  input  logic                            cfg_we_i,
  input  logic [((NUM_SRC>1)?$clog2(NUM_SRC):1)-1:0] cfg_idx_i,
  input  logic [SRV_W-1:0]                cfg_srv_i,
  input  logic [7:0]                      cfg_prio_i,
  input  logic [NUM_SRC-1:0]              issue_i,
  input  logic [NUM_SRC-1:0]              scan_clr_i,
  output logic [NUM_SRC-1:0]              want_o,
  output logic [NUM_SRC-1:0]              rejected_o,
  output logic [NUM_SRC-1:0]              mpend_o,
  output logic [NUM_SRC-1:0][7:0]         prio_o,
  output logic [NUM_SRC-1:0][SRV_W-1:0]   srv_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [7:0]       prio_q;
    logic [SRV_W-1:0] srv_q;
    logic             want_q, rej_q, mp_q;
    logic             hit, fire_m, fire_u, mp_any, want_keep;

    always_comb begin
      hit       = cfg_we_i && (cfg_idx_i == IDX_W'(g));
      fire_m    = fire_i[g] && is_masked(prio_q);
      fire_u    = fire_i[g] && !is_masked(prio_q);
      mp_any    = mp_q | fire_m;
      want_keep = (want_q & ~issue_i[g]) | fire_u;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q <= PRIO_OFF;
        srv_q  <= '0;
        want_q <= 1'b0;
        rej_q  <= 1'b0;
        mp_q   <= 1'b0;
      end else begin
        rej_q <= (rej_q & ~scan_clr_i[g]) | rej_hit_i[g];
        if (hit) begin
          prio_q <= cfg_prio_i;
          srv_q  <= cfg_srv_i;
          if (is_masked(cfg_prio_i)) begin
            mp_q   <= mp_any | want_keep;
            want_q <= 1'b0;
          end else begin
            mp_q   <= 1'b0;
            want_q <= want_keep | mp_any;
          end
        end else begin
          mp_q   <= mp_any;
          want_q <= want_keep;
        end
      end
    end

    assign prio_o[g]     = prio_q;
    assign srv_o[g]      = srv_q;
    assign want_o[g]     = want_q;
    assign rejected_o[g] = rej_q;
    assign mpend_o[g]    = mp_q;

    a_r5_reject_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rej_hit_i[g] |=> rej_q);
    a_r4_no_want_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      want_q |-> !is_masked(prio_q));
    a_r4_masked_fire_remembered: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[g] && is_masked(prio_q) && !cfg_we_i |=> mp_q);
  end

endmodule

// File: rtl/msi_offer_engine.sv
module msi_offer_engine
  import msi_src_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int SRV_W    = 2,
  parameter int NUM_BASE = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          resend_i,
  input  logic [NUM_SRC-1:0]            want_i,
  input  logic [NUM_SRC-1:0]            rejected_i,
  input  logic [NUM_SRC-1:0][7:0]       prio_i,
  input  logic [NUM_SRC-1:0][SRV_W-1:0] srv_i,
  input  logic                          offer_ready_i,
  output logic [NUM_SRC-1:0]            issue_o,
  output logic [NUM_SRC-1:0]            scan_clr_o,
  output logic                          offer_valid_o,
  output logic [31:0]                   offer_num_o,
  output logic [7:0]                    offer_prio_o,
  output logic [SRV_W-1:0]              offer_server_o,
  output logic                          scan_busy_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic             valid_q, busy_q, slot_free, load, any_want;
  logic [IDX_W-1:0] scan_idx_q, pick_idx, load_idx;

  assign slot_free = !valid_q || offer_ready_i;
  assign any_want  = |want_i;

  always_comb begin
    pick_idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (want_i[k]) pick_idx = IDX_W'(k);
  end

  always_comb begin
    issue_o    = '0;
    scan_clr_o = '0;
    load       = 1'b0;
    load_idx   = pick_idx;
    if (slot_free) begin
      if (busy_q) begin
        load_idx = scan_idx_q;
        if (rejected_i[scan_idx_q]) begin
          scan_clr_o[scan_idx_q] = 1'b1;
          load = !is_masked(prio_i[scan_idx_q]);
        end
      end else if (any_want) begin
        issue_o[pick_idx] = 1'b1;
        load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q        <= 1'b0;
      busy_q         <= 1'b0;
      scan_idx_q     <= '0;
      offer_num_o    <= '0;
      offer_prio_o   <= '0;
      offer_server_o <= '0;
    end else begin
      if (load) begin
        valid_q        <= 1'b1;
        offer_num_o    <= 32'(load_idx) + 32'(NUM_BASE);
        offer_prio_o   <= prio_i[load_idx];
        offer_server_o <= srv_i[load_idx];
      end else if (offer_ready_i) begin
        valid_q <= 1'b0;
      end
      if (!busy_q) begin
        if (resend_i) begin
          busy_q     <= 1'b1;
          scan_idx_q <= '0;
        end
      end else if (slot_free) begin
        if (scan_idx_q == LAST_IDX) busy_q <= 1'b0;
        else scan_idx_q <= scan_idx_q + 1'b1;
      end
    end
  end

  assign offer_valid_o = valid_q;
  assign scan_busy_o   = busy_q;

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !offer_ready_i |=> valid_q && $stable(offer_num_o)
      && $stable(offer_prio_o) && $stable(offer_server_o));
  a_r3_offer_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !is_masked(offer_prio_o));
  a_r1_offer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> num_ok(offer_num_o, NUM_BASE, NUM_SRC));
  a_r6_scan_waits: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && valid_q && !offer_ready_i |=> busy_q && $stable(scan_idx_q));

endmodule

// File: rtl/msi_cfg_port.sv
module msi_cfg_port
  import msi_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int NUM_BASE    = 16,
  parameter int SRV_W       = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr_i,
  input  logic                          cfg_rd_i,
  input  logic [31:0]                   cfg_num_i,
  input  logic [31:0]                   cfg_server_i,
  input  logic [31:0]                   cfg_prio_i,
  input  logic [NUM_SRC-1:0][7:0]       prio_i,
  input  logic [NUM_SRC-1:0][SRV_W-1:0] srv_i,
  output logic                          we_o,
  output logic [((NUM_SRC>1)?$clog2(NUM_SRC):1)-1:0] idx_o,
  output logic [SRV_W-1:0]              srv_o,
  output logic [7:0]                    prio_o,
  output logic                          done_o,
  output logic [31:0]                   status_o,
  output logic [31:0]                   rd_srv_o,
  output logic [7:0]                    rd_prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic num_valid, wr_good;
  logic [31:0] local_num;

  assign local_num = cfg_num_i - 32'(NUM_BASE);
  assign num_valid = num_ok(cfg_num_i, NUM_BASE, NUM_SRC);
  assign wr_good   = wr_ok(cfg_num_i, cfg_server_i, cfg_prio_i, NUM_BASE, NUM_SRC, NUM_SERVERS);
  assign we_o      = cfg_wr_i && wr_good;
  assign idx_o     = IDX_W'(local_num);
  assign srv_o     = SRV_W'(cfg_server_i);
  assign prio_o    = cfg_prio_i[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      status_o  <= ST_OK;
      rd_srv_o  <= '0;
      rd_prio_o <= '0;
    end else begin
      done_o    <= cfg_wr_i || cfg_rd_i;
      rd_srv_o  <= '0;
      rd_prio_o <= '0;
      if (cfg_wr_i) begin
        status_o <= wr_good ? ST_OK : ST_ERR;
      end else if (cfg_rd_i) begin
        status_o <= num_valid ? ST_OK : ST_ERR;
        if (num_valid) begin
          rd_srv_o  <= 32'(srv_i[idx_o]);
          rd_prio_o <= prio_i[idx_o];
        end
      end
    end
  end

  a_r7_done_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i || cfg_rd_i |=> done_o);
  a_r7_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o == ST_OK) || (status_o == ST_ERR));
  a_r8_bad_read_error: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_i && !cfg_wr_i && !num_valid |=> status_o == ST_ERR);

endmodule

// File: rtl/msi_src_ctl.sv
module msi_src_ctl
  import msi_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int NUM_BASE    = 16,
  localparam int SRV_W      = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_fire_i,
  output logic               offer_valid_o,
  input  logic               offer_ready_i,
  output logic [31:0]        offer_num_o,
  output logic [7:0]         offer_prio_o,
  output logic [SRV_W-1:0]   offer_server_o,
  input  logic               reject_valid_i,
  input  logic [31:0]        reject_num_i,
  input  logic               eoi_valid_i,
  input  logic [31:0]        eoi_num_i,
  input  logic               resend_i,
  output logic               scan_busy_o,
  input  logic               cfg_wr_i,
  input  logic               cfg_rd_i,
  input  logic [31:0]        cfg_num_i,
  input  logic [31:0]        cfg_server_i,
  input  logic [31:0]        cfg_prio_i,
  output logic               cfg_done_o,
  output logic [31:0]        cfg_status_o,
  output logic [31:0]        cfg_server_o,
  output logic [7:0]         cfg_prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]            rej_hit, want, rejected, mpend, issue, scan_clr;
  logic [NUM_SRC-1:0][7:0]       prio;
  logic [NUM_SRC-1:0][SRV_W-1:0] srv;
  logic                          cfg_we;
  logic [IDX_W-1:0]              cfg_idx;
  logic [SRV_W-1:0]              cfg_srv;
  logic [7:0]                    cfg_prio;
  logic                          reject_ok;
  logic [31:0]                   reject_local;

  assign reject_ok    = reject_valid_i && num_ok(reject_num_i, NUM_BASE, NUM_SRC);
  assign reject_local = reject_num_i - 32'(NUM_BASE);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rej
    assign rej_hit[g] = reject_ok && (IDX_W'(reject_local) == IDX_W'(g));
  end

  msi_cfg_port #(
    .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .NUM_BASE(NUM_BASE), .SRV_W(SRV_W)
  ) u_cfg (
    .clk, .rst_n, .cfg_wr_i, .cfg_rd_i, .cfg_num_i, .cfg_server_i, .cfg_prio_i,
    .prio_i(prio), .srv_i(srv),
    .we_o(cfg_we), .idx_o(cfg_idx), .srv_o(cfg_srv), .prio_o(cfg_prio),
    .done_o(cfg_done_o), .status_o(cfg_status_o),
    .rd_srv_o(cfg_server_o), .rd_prio_o(cfg_prio_o)
  );

  msi_src_table #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W)) u_tab (
    .clk, .rst_n, .fire_i(src_fire_i), .rej_hit_i(rej_hit),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_srv_i(cfg_srv), .cfg_prio_i(cfg_prio),
    .issue_i(issue), .scan_clr_i(scan_clr),
    .want_o(want), .rejected_o(rejected), .mpend_o(mpend), .prio_o(prio), .srv_o(srv)
  );

  msi_offer_engine #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_BASE(NUM_BASE)) u_eng (
    .clk, .rst_n, .resend_i, .want_i(want), .rejected_i(rejected),
    .prio_i(prio), .srv_i(srv), .offer_ready_i,
    .issue_o(issue), .scan_clr_o(scan_clr),
    .offer_valid_o, .offer_num_o, .offer_prio_o, .offer_server_o, .scan_busy_o
  );

  a_r9_eoi_inert: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid_i && num_ok(eoi_num_i, NUM_BASE, NUM_SRC) && !reject_valid_i && !scan_busy_o
      |=> $stable(rejected));
  a_r4_pending_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mpend & ~want) == mpend);

endmodule

// File: tb/msi_src_ctl_test.sv
module msi_src_ctl_test;
  localparam int NSRC = 8;
  localparam int NSRV = 4;
  localparam int BASE = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_fire = '0;
  logic offer_valid, offer_ready = 1'b1;
  logic [31:0] offer_num;
  logic [7:0] offer_prio;
  logic [1:0] offer_server;
  logic reject_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0, scan_busy;
  logic [31:0] reject_num = '0, eoi_num = '0;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_done;
  logic [31:0] cfg_num = '0, cfg_server = '0, cfg_prio = '0, cfg_status, cfg_server_o;
  logic [7:0] cfg_prio_o;

  msi_src_ctl #(.NUM_SRC(NSRC), .NUM_SERVERS(NSRV), .NUM_BASE(BASE)) uut (
    .clk, .rst_n, .src_fire_i(src_fire), .offer_valid_o(offer_valid), .offer_ready_i(offer_ready),
    .offer_num_o(offer_num), .offer_prio_o(offer_prio), .offer_server_o(offer_server),
    .reject_valid_i(reject_valid), .reject_num_i(reject_num),
    .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num), .resend_i(resend), .scan_busy_o(scan_busy),
    .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_num_i(cfg_num), .cfg_server_i(cfg_server),
    .cfg_prio_i(cfg_prio), .cfg_done_o(cfg_done), .cfg_status_o(cfg_status),
    .cfg_server_o(cfg_server_o), .cfg_prio_o(cfg_prio_o)
  );

  int total = 0, bad = 0;
  int q_num[$];
  int q_prio[$];
  int q_srv[$];

  always @(posedge clk)
    if (rst_n && offer_valid && offer_ready) begin
      q_num.push_back(int'(offer_num));
      q_prio.push_back(int'(offer_prio));
      q_srv.push_back(int'(offer_server));
    end

  function automatic int exp_prio(int i); return 8'h10 + i * 5; endfunction
  function automatic int exp_srv(int i);  return (i * 3) % NSRV; endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int num, input int srv, input int prio, input int est, input string tag);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_num = num; cfg_server = srv; cfg_prio = prio;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(cfg_done && cfg_status == est, tag, int'(cfg_status), est);
  endtask

  task automatic cfg_read(input int num, input int est, input int srv, input int prio, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_num = num;
    @(negedge clk);
    cfg_rd = 1'b0;
    check(cfg_done && cfg_status == est, tag, int'(cfg_status), est);
    if (est == 0) begin
      check(cfg_server_o == srv, tag, int'(cfg_server_o), srv);
      check(cfg_prio_o == prio, tag, int'(cfg_prio_o), prio);
    end
  endtask

  task automatic fire(input logic [NSRC-1:0] m);
    @(negedge clk); src_fire = m;
    @(negedge clk); src_fire = '0;
  endtask

  task automatic pulse_reject(input int num);
    @(negedge clk); reject_valid = 1'b1; reject_num = num;
    @(negedge clk); reject_valid = 1'b0;
  endtask

  task automatic pulse_resend();
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic expect_offer(input int num, input string tag);
    int i = num - BASE;
    if (q_num.size() == 0) check(1'b0, tag, -1, num);
    else begin
      int an = q_num.pop_front();
      int ap = q_prio.pop_front();
      int as = q_srv.pop_front();
      check(an == num, tag, an, num);
      check(ap == exp_prio(i), tag, ap, exp_prio(i));
      check(as == exp_srv(i), tag, as, exp_srv(i));
    end
  endtask

  task automatic expect_none(input string tag);
    check(q_num.size() == 0, tag, q_num.size(), 0);
    q_num.delete(); q_prio.delete(); q_srv.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R2: reset state
    check(!offer_valid, "R2 no offer after reset", offer_valid, 0);
    for (int i = 0; i < NSRC; i++) cfg_read(BASE + i, 0, 0, 8'hFF, "R2 reset readback");
    // R1 / R8: range of valid numbers on reads
    cfg_read(BASE - 1, 32'hFFFF_FFFD, 0, 0, "R1 R8 read below base");
    cfg_read(BASE + NSRC, 32'hFFFF_FFFD, 0, 0, "R1 R8 read above top");
    cfg_read(32'hFFFF_FFFF, 32'hFFFF_FFFD, 0, 0, "R8 read huge number");
    // R7: rejected writes leave state untouched
    cfg_write(BASE - 1, 0, 1, 32'hFFFF_FFFD, "R7 write below base");
    cfg_write(BASE + NSRC, 0, 1, 32'hFFFF_FFFD, "R7 write above top");
    cfg_write(BASE, NSRV, 1, 32'hFFFF_FFFD, "R7 write bad server");
    cfg_write(BASE, 0, 256, 32'hFFFF_FFFD, "R7 write prio over 0xFF");
    cfg_read(BASE, 0, 0, 8'hFF, "R7 state unchanged after bad writes");
    // R7 / R8: configure all, read back sweep
    for (int i = 0; i < NSRC; i++) cfg_write(BASE + i, exp_srv(i), exp_prio(i), 0, "R7 good write");
    for (int i = 0; i < NSRC; i++) cfg_read(BASE + i, 0, exp_srv(i), exp_prio(i), "R8 readback");
    expect_none("R7 writes offer nothing");
    // R3: individual fires
    for (int i = 0; i < NSRC; i++) begin
      fire(NSRC'(1) << i); idle(3);
      expect_offer(BASE + i, "R3 single fire");
      expect_none("R3 only one offer");
    end
    // R3: all at once, lowest first
    fire('1); idle(NSRC + 3);
    for (int i = 0; i < NSRC; i++) expect_offer(BASE + i, "R3 ascending order");
    expect_none("R3 no extra offers");
    // R4: masked fire remembered
    cfg_write(BASE + 3, exp_srv(3), 8'hFF, 0, "R4 mask source");
    fire(8'h08); idle(5);
    expect_none("R4 masked fire silent");
    cfg_write(BASE + 3, exp_srv(3), 8'hFF, 0, "R4 rewrite masked");
    idle(4);
    expect_none("R4 still masked no offer");
    cfg_write(BASE + 3, exp_srv(3), exp_prio(3), 0, "R4 unmask");
    idle(3);
    expect_offer(BASE + 3, "R4 delivered on unmask");
    cfg_write(BASE + 3, exp_srv(3), exp_prio(3), 0, "R4 second unmask write");
    idle(3);
    expect_none("R4 delivered only once");
    // R5: reject and resend
    cfg_write(BASE + 6, exp_srv(6), 8'hFF, 0, "R5 mask source 6");
    pulse_reject(BASE + 1); pulse_reject(BASE + 4); pulse_reject(BASE + 6);
    pulse_resend(); idle(NSRC + 4);
    expect_offer(BASE + 1, "R5 resend first");
    expect_offer(BASE + 4, "R5 resend second");
    expect_none("R5 masked rejected not offered");
    pulse_resend(); idle(NSRC + 4);
    expect_none("R5 flags cleared by resend");
    cfg_write(BASE + 6, exp_srv(6), exp_prio(6), 0, "R5 unmask source 6");
    idle(3);
    expect_none("R5 masked reject cleared silently");
    // R6: stall holds payload
    @(negedge clk); offer_ready = 1'b0;
    fire(8'h01); idle(2);
    check(offer_valid && offer_num == BASE, "R6 stalled offer visible", int'(offer_num), BASE);
    fire(8'h02); idle(3);
    check(offer_valid && offer_num == BASE, "R6 payload held", int'(offer_num), BASE);
    @(negedge clk); offer_ready = 1'b1;
    idle(4);
    expect_offer(BASE, "R6 stalled offer delivered");
    expect_offer(BASE + 1, "R6 queued fire delivered");
    expect_none("R6 no extra after stall");
    // R6: scan stall with fire during scan
    pulse_reject(BASE); pulse_reject(BASE + 7);
    @(negedge clk); offer_ready = 1'b0;
    pulse_resend(); idle(2);
    fire(8'h20); idle(4);
    check(scan_busy == 1'b1, "R6 scan waits on stall", scan_busy, 1);
    @(negedge clk); offer_ready = 1'b1;
    idle(NSRC + 6);
    check(!scan_busy, "R6 scan finished", scan_busy, 0);
    expect_offer(BASE, "R6 scan first");
    expect_offer(BASE + 7, "R6 scan last");
    expect_offer(BASE + 5, "R6 fire queued during scan");
    expect_none("R6 nothing else");
    // R9: EOI leaves rejected flag
    pulse_reject(BASE + 2);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = BASE + 2;
    @(negedge clk); eoi_valid = 1'b0;
    idle(2);
    expect_none("R9 EOI offers nothing");
    pulse_resend(); idle(NSRC + 4);
    expect_offer(BASE + 2, "R9 reject survives EOI");
    expect_none("R9 no extra");
    cfg_read(BASE + 2, 0, exp_srv(2), exp_prio(2), "R9 config unchanged by EOI");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule